// File: doc/BRIEF.md
# Scanned LED Matrix Framestore Controller

This block refreshes a column-multiplexed LED matrix out of a small on-chip word store and lets a user place a pattern into any column with a push button. A single free-running scan counter plays two roles. It selects which matrix column is lit, and it addresses the store, whose word drives the seven row lines of that column. Two 5×7 panels sit side by side and use columns 0 to 9. Columns 10 to 15 are still visited by the scan but never light anything.

A press of the write button first passes through a synchronising register. The controller then loads the scan counter from the column-select input, so the counter now acts as the write address. It hands the internal data bus from the store's read port to the switch-data driver and pulses an active-low write strobe. Once the strobe has ended it returns the bus to the store and lets the scan carry on from the written column. A second button wipes the whole store, one address after another, through the same load/strobe/hold phases.

Top module: `led_framestore`

## Requirements
- R1: In reset `col_addr` is 0. While scanning, `col_addr` increases by one every clock and wraps from 15 to 0.
- R2: While scanning a column below 10, `rows` equals the 7-bit word stored at that column.
- R3: While scanning columns 10 to 15, `rows` is all zero, whatever those addresses hold.
- R4: A write button that goes high before clock edge k is registered at edge k. At edge k+1 the first write phase begins: `col_addr` shows `col_sel` and `rows` is zero, because neither bus driver is enabled.
- R5: In the two phases that follow (strobe low, then strobe high with data held), `col_addr` stays at the loaded column and `rows` shows `row_sw`. The write strobe is low for exactly one cycle.
- R6: After the hold phase, scanning resumes with `col_addr` still on the written column for one cycle. The column then shows the word that was written, subject to R3, and counting continues from there.
- R7: One press performs exactly one write, however long the button is held. A new write is accepted only after the registered button has been seen low.
- R8: A clear press (same synchronisation and start timing as R4) writes zero to addresses 0 to 15 in order. Each address takes three cycles (load, strobe, hold), and `rows` is zero throughout. Scanning then resumes at column 15.
- R9: If write and clear become eligible in the same cycle, the write runs first. A clear still pending then starts one scan cycle after the write completes.
- R10: The store read port and the switch driver never drive the bus together, and the address does not change while the strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_btn | input | 1 | Write push button, asynchronous to clk |
| clr_btn | input | 1 | Clear-all push button, asynchronous to clk |
| col_sel | input | 4 | Target column for a write |
| row_sw | input | 7 | Row pattern to write |
| col_addr | output | 4 | Scan counter: matrix column select and store address |
| rows | output | 7 | Row drive for the selected column |

## Verification
The bench aims at the handover points of the shared counter. If the first write phase drove the bus too early, `rows` would show switch data instead of zero. A design that kept counting through the strobe would write to the wrong column. A design that lost a cycle on resuming would show the written column one cycle short or skip it. A held button exercises rearming: a design that restarts on the level rather than on a fresh press would interrupt the scan again. Writes to columns 0, 9, 12 and 15 probe the edge of the lit area and the wrap of the counter. A simultaneous write-and-clear press checks that the write is not lost behind the clear.

// File: rtl/fs_pkg.sv
package fs_pkg;
    localparam int COL_W    = 4;
    localparam int ROW_W    = 7;
    localparam int LIT_COLS = 10;

    typedef enum logic [1:0] {
        PH_SCAN,
        PH_LOAD,
        PH_STROBE,
        PH_HOLD
    } phase_t;

    typedef struct packed {
        logic mem_oe;
        logic drv_en;
        logic we_n;
    } bus_ctl_t;

    function automatic bus_ctl_t phase_ctl(phase_t p);
        bus_ctl_t c;
        c.mem_oe = (p == PH_SCAN);
        c.drv_en = (p == PH_STROBE) || (p == PH_HOLD);
        c.we_n   = (p != PH_STROBE);
        return c;
    endfunction
endpackage

// File: rtl/fs_press.sv
module fs_press (
    input  logic clk,
    input  logic rst,
    input  logic btn,
    input  logic ready,
    output logic fire
);
    logic btn_q;
    logic armed;

    assign fire = btn_q && armed && ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            btn_q <= 1'b0;
            armed <= 1'b1;
        end else begin
            btn_q <= btn;
            if (!btn_q)
                armed <= 1'b1;
            else if (fire)
                armed <= 1'b0;
        end
    end
endmodule

// File: rtl/fs_ctrl.sv
module fs_ctrl
    import fs_pkg::*;
#(
    parameter int COL_W = fs_pkg::COL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_go,
    input  logic             clr_go,
    input  logic [COL_W-1:0] col_sel,
    output logic [COL_W-1:0] cnt,
    output phase_t           phase,
    output logic             clearing
);
    localparam logic [COL_W-1:0] LAST = {COL_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_SCAN;
            cnt      <= '0;
            clearing <= 1'b0;
        end else begin
            unique case (phase)
                PH_SCAN: begin
                    if (wr_go) begin
                        phase    <= PH_LOAD;
                        cnt      <= col_sel;
                        clearing <= 1'b0;
                    end else if (clr_go) begin
                        phase    <= PH_LOAD;
                        cnt      <= '0;
                        clearing <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                PH_LOAD:   phase <= PH_STROBE;
                PH_STROBE: phase <= PH_HOLD;
                PH_HOLD: begin
                    if (clearing && cnt != LAST) begin
                        cnt   <= cnt + 1'b1;
                        phase <= PH_LOAD;
                    end else begin
                        phase    <= PH_SCAN;
                        clearing <= 1'b0;
                    end
                end
                default: phase <= PH_SCAN;
            endcase
        end
    end
endmodule

// File: rtl/fs_mem.sv
module fs_mem #(
    parameter int COL_W = fs_pkg::COL_W,
    parameter int ROW_W = fs_pkg::ROW_W
) (
    input  logic             clk,
    input  logic             we_n,
    input  logic [COL_W-1:0] addr,
    input  logic [ROW_W-1:0] wdata,
    output logic [ROW_W-1:0] rdata
);
    localparam int DEPTH = 1 << COL_W;

    logic [ROW_W-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (!we_n)
            store[addr] <= wdata;
    end

    assign rdata = store[addr];
endmodule

// File: rtl/led_framestore.sv
module led_framestore
    import fs_pkg::*;
#(
    parameter int COL_W    = fs_pkg::COL_W,
    parameter int ROW_W    = fs_pkg::ROW_W,
    parameter int LIT_COLS = fs_pkg::LIT_COLS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_btn,
    input  logic             clr_btn,
    input  logic [COL_W-1:0] col_sel,
    input  logic [ROW_W-1:0] row_sw,
    output logic [COL_W-1:0] col_addr,
    output logic [ROW_W-1:0] rows
);
    localparam logic [COL_W-1:0] LIT_LIM = COL_W'(LIT_COLS);

    phase_t           phase;
    logic             clearing;
    logic             wr_go;
    logic             clr_go;
    logic             idle;
    bus_ctl_t         ctl;
    logic             we_n;
    logic             drv_en;
    logic             mem_oe;
    logic [ROW_W-1:0] rd_word;
    logic [ROW_W-1:0] drv_word;
    logic [ROW_W-1:0] bus;

    assign idle = (phase == PH_SCAN);

    fs_press u_wr (
        .clk  (clk),
        .rst  (rst),
        .btn  (wr_btn),
        .ready(idle),
        .fire (wr_go)
    );

    fs_press u_clr (
        .clk  (clk),
        .rst  (rst),
        .btn  (clr_btn),
        .ready(idle && !wr_go),
        .fire (clr_go)
    );

    fs_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_go   (wr_go),
        .clr_go  (clr_go),
        .col_sel (col_sel),
        .cnt     (col_addr),
        .phase   (phase),
        .clearing(clearing)
    );

    assign ctl    = phase_ctl(phase);
    assign we_n   = ctl.we_n;
    assign drv_en = ctl.drv_en;
    assign mem_oe = ctl.mem_oe;

    assign drv_word = clearing ? '0 : row_sw;
    assign bus      = drv_en ? drv_word : (mem_oe ? rd_word : '0);

    fs_mem #(.COL_W(COL_W), .ROW_W(ROW_W)) u_mem (
        .clk  (clk),
        .we_n (we_n),
        .addr (col_addr),
        .wdata(bus),
        .rdata(rd_word)
    );

    assign rows = (mem_oe && col_addr >= LIT_LIM) ? '0 : bus;
endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
    parameter int COL_W    = 4,
    parameter int ROW_W    = 7,
    parameter int LIT_COLS = 10
) (
    input logic             clk,
    input logic             rst,
    input logic [COL_W-1:0] col_addr,
    input logic [ROW_W-1:0] rows,
    input logic             we_n,
    input logic             drv_en,
    input logic             mem_oe
);
    localparam logic [COL_W-1:0] LIT_LIM = COL_W'(LIT_COLS);

    p_no_contention_r10: assert property (@(posedge clk) disable iff (rst)
        !(drv_en && mem_oe));

    p_addr_stable_r10: assert property (@(posedge clk) disable iff (rst)
        !we_n |-> $stable(col_addr));

    p_strobe_single_r5: assert property (@(posedge clk) disable iff (rst)
        !we_n |=> we_n);

    p_strobe_after_gap_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(we_n) |-> (!$past(drv_en) && !$past(mem_oe)));

    p_scan_step_r1: assert property (@(posedge clk) disable iff (rst)
        (mem_oe && $past(mem_oe) && !$past(rst)) |->
            col_addr == ($past(col_addr) + COL_W'(1)));

    p_dark_cols_r3: assert property (@(posedge clk) disable iff (rst)
        (mem_oe && col_addr >= LIT_LIM) |-> rows == '0);
endmodule

bind led_framestore fs_checker #(
    .COL_W(COL_W),
    .ROW_W(ROW_W),
    .LIT_COLS(LIT_COLS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .col_addr(col_addr),
    .rows    (rows),
    .we_n    (we_n),
    .drv_en  (drv_en),
    .mem_oe  (mem_oe)
);

// File: tb/sim_led_framestore.sv
module sim_led_framestore;
    localparam int CLK_NS = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_btn = 1'b0;
    logic       clr_btn = 1'b0;
    logic [3:0] col_sel = '0;
    logic [6:0] row_sw = '0;
    wire  [3:0] col_addr;
    wire  [6:0] rows;

    led_framestore u0 (
        .clk     (clk),
        .rst     (rst),
        .wr_btn  (wr_btn),
        .clr_btn (clr_btn),
        .col_sel (col_sel),
        .row_sw  (row_sw),
        .col_addr(col_addr),
        .rows    (rows)
    );

    always #(CLK_NS/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    typedef struct {
        int         due;
        logic [3:0] col;
        logic [6:0] rws;
        bit         ck_rows;
        string      tag;
    } exp_t;

    exp_t       q[$];
    int         total = 0;
    int         bad = 0;
    logic [6:0] model [16];
    int         anc_cyc = 0;
    int         anc_col = 0;

    function automatic logic [6:0] vis(int c);
        return (c < 10) ? model[c] : 7'h00;
    endfunction

    function automatic int scan_col(int t);
        return (anc_col + t - anc_cyc) % 16;
    endfunction

    task automatic push(int due, int col, logic [6:0] r, bit ckr, string tag);
        exp_t e;
        e.due = due; e.col = 4'(col); e.rws = r; e.ck_rows = ckr; e.tag = tag;
        q.push_back(e);
    endtask

    // monitor: sample a quarter period after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_NS/4);
            while (q.size() > 0 && q[0].due <= cyc) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if (e.due != cyc || col_addr !== e.col ||
                    (e.ck_rows && rows !== e.rws)) begin
                    bad++;
                    $display("FAIL %s cyc=%0d: col=%0d rows=%h, expected col=%0d rows=%h",
                             e.tag, e.due, col_addr, rows, e.col, e.rws);
                end
            end
        end
    end

    task automatic wait_to(int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic scan(int n, bit ckr, string tag);
        int c;
        @(negedge clk);
        c = cyc;
        for (int j = 1; j <= n; j++)
            push(c + j, scan_col(c + j), vis(scan_col(c + j)), ckr, tag);
        wait_to(c + n);
    endtask

    task automatic do_write(int wc, logic [6:0] d, int hold);
        int c;
        @(negedge clk);
        c = cyc;
        col_sel = 4'(wc); row_sw = d; wr_btn = 1'b1;
        push(c + 2, wc, 7'h00, 1'b1, "R4");
        push(c + 3, wc, d, 1'b1, "R5");
        push(c + 4, wc, d, 1'b1, "R5");
        model[wc] = d;
        anc_cyc = c + 5; anc_col = wc;
        push(c + 5, wc, vis(wc), 1'b1, "R6");
        for (int j = 1; j <= hold; j++)
            push(c + 5 + j, scan_col(c + 5 + j), vis(scan_col(c + 5 + j)), 1'b1, "R7");
        wait_to(c + 5);
        row_sw = ~d; col_sel = 4'(wc + 7);
        wait_to(c + hold);
        wr_btn = 1'b0;
        wait_to(c + 5 + hold);
    endtask

    task automatic push_clear(int b);
        for (int k = 0; k < 16; k++) begin
            push(b + 2 + 3*k, k, 7'h00, 1'b1, "R8");
            push(b + 3 + 3*k, k, 7'h00, 1'b1, "R8");
            push(b + 4 + 3*k, k, 7'h00, 1'b1, "R8");
        end
        push(b + 50, 15, 7'h00, 1'b1, "R8");
        for (int k = 0; k < 16; k++) model[k] = 7'h00;
        anc_cyc = b + 50; anc_col = 15;
    endtask

    task automatic do_clear();
        int c;
        @(negedge clk);
        c = cyc;
        clr_btn = 1'b1;
        push_clear(c);
        wait_to(c + 3);
        clr_btn = 1'b0;
        wait_to(c + 50);
    endtask

    task automatic do_both(int wc, logic [6:0] d);
        int c;
        @(negedge clk);
        c = cyc;
        col_sel = 4'(wc); row_sw = d; wr_btn = 1'b1; clr_btn = 1'b1;
        push(c + 2, wc, 7'h00, 1'b1, "R9");
        push(c + 3, wc, d, 1'b1, "R9");
        push(c + 4, wc, d, 1'b1, "R9");
        model[wc] = d;
        push(c + 5, wc, vis(wc), 1'b1, "R9");
        push_clear(c + 4);
        wait_to(c + 5);
        wr_btn = 1'b0; clr_btn = 1'b0;
        wait_to(c + 54);
    endtask

    bit finished = 1'b0;

    initial begin
        #(CLK_NS * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        total++;
        if (col_addr !== 4'd0) begin
            bad++;
            $display("FAIL R1 reset: col=%0d expected 0", col_addr);
        end
        rst = 1'b0;
        anc_cyc = 0; anc_col = 0;
        scan(20, 1'b0, "R1");          // counter only; store contents unknown
        do_clear();                    // R8
        scan(20, 1'b1, "R2");          // R1 R2 R3 on a blank store
        do_write(3, 7'h55, 6);         // R4 R5 R6
        scan(18, 1'b1, "R2");
        do_write(12, 7'h7f, 6);        // dark column: R3
        do_write(9, 7'h2a, 6);         // last lit column
        do_write(0, 7'h01, 6);
        do_write(15, 7'h33, 6);        // wrap after resume
        do_write(6, 7'h4c, 25);        // long hold: R7 one write per press
        do_write(7, 7'h19, 6);         // rearmed after release: R7
        scan(32, 1'b1, "R2");
        do_both(5, 7'h66);             // R9
        scan(20, 1'b1, "R3");
        wait_to(cyc + 2);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule